// File: doc/BRIEF.md
# Dual-Bank Read Data Router

This block decides what a bus read returns on a flash-style memory whose array is split into two banks. Each bank holds its own operating mode: plain array reads, identification (auto-select) reads, query-table reads, programming, or a latched program error. A read is steered to one of the two banks by the two highest address bits. The addressed bank's mode then picks among array data, fixed identification codes, per-block protection flags, the extended-block verify code, query-table data and the status byte. Because modes are kept per bank, a bank that is not in a special mode keeps answering with array contents while the other bank is busy or showing codes.

Array words, query-table words, the status byte, the protection map and the program/erase controller's busy and error flags are all supplied from outside. The router only tracks per-bank mode from decoded command events and muxes the right source onto a registered output. In byte-wide operation an extra low address input picks the byte lane of array words, and the upper data lane is released.

Top module: `dual_bank_read_router`

## Requirements
- R1: While `rst` is high and on the first edge after it, `rd_data` is 0, `rd_hi_en` is 0 and both banks are in array mode.
- R2: Bank A is addressed when `rd_addr[20:19]` equals 2'b11 with `cfg_top_boot`=1 or 2'b00 with `cfg_top_boot`=0, and bank B is addressed otherwise. The read result is registered, so it appears one clock after the address. A bank in array mode returns `array_word` even while the other bank is in a special mode.
- R3: A bank in auto-select mode returns 0x0020 for `rd_addr[1:0]`=00. For `rd_addr[1:0]`=01 it returns 0x225E when `cfg_top_boot`=1 and 0x225F when it is 0. In byte mode only the low byte (0x20, 0x5E, 0x5F) is returned.
- R4: In auto-select mode, `rd_addr[1:0]`=10 returns 0x0001 when bit {bank,`rd_addr[18:12]`} of `prot_map` is set (bank A=0, B=1) and 0x0000 otherwise. `rd_addr[1:0]`=11 with `rd_addr[6]`=0 returns 0x0081 when `ext_locked`=1 and 0x0001 when it is 0. With `rd_addr[6]`=1 it returns 0x0000.
- R5: `cmd_op`=2 (query) moves a bank from array or auto-select mode to query mode, where reads return `cfi_word`. `cmd_op`=0 (reset) then returns it to the mode it came from. A reset in auto-select mode returns to array mode. `cmd_op`=1 is auto-select entry.
- R6: `cmd_op`=3 (program) moves an array-mode bank to programming, and its reads return {8'h00,`status_byte`}. Once `pe_busy` for that bank has been seen high, the first cycle it is low with `pe_error` low already returns array data, and the bank is back in array mode.
- R7: If `pe_error` is high in the cycle busy falls, the bank keeps returning status until a reset command reaches it. Other commands to it have no effect.
- R8: Commands to a programming bank are ignored. A program command is refused while the other bank is programming. Program commands to a bank in auto-select or query mode are ignored.
- R9: With `rd_byte_mode`=1, `rd_hi_en` is 0 and `rd_data[15:8]` is 0. Array reads return the high byte of `array_word` when `rd_byte_hi`=1 and the low byte when it is 0. Codes, query and status return their low byte. With `rd_byte_mode`=0, `rd_hi_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 21 | Word address of the read |
| rd_byte_mode | input | 1 | 1 = byte-wide bus |
| rd_byte_hi | input | 1 | Byte lane select in byte mode |
| cfg_top_boot | input | 1 | 1 = parameter blocks at top of map |
| ext_locked | input | 1 | Extended block factory locked |
| prot_map | input | 256 | Protection flag per {bank, block} |
| array_word | input | 16 | Array data at `rd_addr` |
| cfi_word | input | 16 | Query-table data at `rd_addr` |
| status_byte | input | 8 | Program/erase status byte |
| cmd_valid | input | 1 | Decoded command event |
| cmd_op | input | 2 | 0 reset, 1 auto-select, 2 query, 3 program |
| cmd_bank | input | 1 | Target bank of the command (0 = A) |
| pe_busy | input | 2 | Per-bank controller busy |
| pe_error | input | 2 | Per-bank controller error flag |
| rd_data | output | 16 | Registered read data |
| rd_hi_en | output | 1 | Upper lane driven |

## Verification
The bench builds the router with its default parameters: a 21-bit address, a 16-bit data path and block-select bits starting at bit 12. That gives a 7-bit block index per bank and a 256-entry protection map, so every protection flag of both banks can be reached by random addresses. Half of the random addresses are forced into bank A, so both banks and both boot orientations (the orientation is flipped during the run) see code and array reads. Busy pulses of random length are generated against the bench's own mode model, which reaches error latching, refused second programs and the same-cycle return to array data.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [2:0] {
    MD_ARRAY = 3'd0,
    MD_AUTO  = 3'd1,
    MD_CFI   = 3'd2,
    MD_PROG  = 3'd3,
    MD_ERR   = 3'd4
  } bank_mode_e;

  typedef enum logic [1:0] {
    OP_RESET   = 2'd0,
    OP_AUTOSEL = 2'd1,
    OP_CFI     = 2'd2,
    OP_PROGRAM = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_CODE   = 2'd1,
    SRC_CFI    = 2'd2,
    SRC_STATUS = 2'd3
  } src_e;

  localparam logic [7:0] MFR_CODE  = 8'h20;
  localparam logic [7:0] DEV_UPPER = 8'h22;
  localparam logic [7:0] DEV_TOP   = 8'h5E;
  localparam logic [7:0] DEV_BOT   = 8'h5F;
  localparam logic [7:0] XV_LOCKED = 8'h81;
  localparam logic [7:0] XV_OPEN   = 8'h01;

endpackage

// File: rtl/dbr_bank_mode.sv
module dbr_bank_mode
  import dbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_hit,
  input  cmd_op_e    cmd_op,
  input  logic       other_prog,
  input  logic       busy,
  input  logic       err,
  output bank_mode_e mode,
  output src_e       src
);

  bank_mode_e mode_d;
  logic       seen_q, seen_d;
  logic       ret_auto_q, ret_auto_d;

  always_comb begin
    mode_d     = mode;
    seen_d     = seen_q;
    ret_auto_d = ret_auto_q;
    unique case (mode)
      MD_ARRAY: if (cmd_hit) begin
        if (cmd_op == OP_AUTOSEL) mode_d = MD_AUTO;
        else if (cmd_op == OP_CFI) begin
          mode_d     = MD_CFI;
          ret_auto_d = 1'b0;
        end else if (cmd_op == OP_PROGRAM && !other_prog) begin
          mode_d = MD_PROG;
          seen_d = 1'b0;
        end
      end
      MD_AUTO: if (cmd_hit) begin
        if (cmd_op == OP_RESET) mode_d = MD_ARRAY;
        else if (cmd_op == OP_CFI) begin
          mode_d     = MD_CFI;
          ret_auto_d = 1'b1;
        end
      end
      MD_CFI: if (cmd_hit && cmd_op == OP_RESET)
        mode_d = ret_auto_q ? MD_AUTO : MD_ARRAY;
      MD_PROG: begin
        if (busy) seen_d = 1'b1;
        else if (seen_q) mode_d = err ? MD_ERR : MD_ARRAY;
      end
      MD_ERR: if (cmd_hit && cmd_op == OP_RESET) mode_d = MD_ARRAY;
      default: mode_d = MD_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= MD_ARRAY;
      seen_q     <= 1'b0;
      ret_auto_q <= 1'b0;
    end else begin
      mode       <= mode_d;
      seen_q     <= seen_d;
      ret_auto_q <= ret_auto_d;
    end
  end

  // Completion without error shows array data in the very cycle busy drops.
  always_comb begin
    unique case (mode)
      MD_AUTO: src = SRC_CODE;
      MD_CFI:  src = SRC_CFI;
      MD_ERR:  src = SRC_STATUS;
      MD_PROG: src = (seen_q && !busy && !err) ? SRC_ARRAY : SRC_STATUS;
      default: src = SRC_ARRAY;
    endcase
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_ERR && !(cmd_hit && cmd_op == OP_RESET)) |=> mode == MD_ERR); // R7

  AST_PROG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_PROG && busy) |=> mode == MD_PROG); // R8

  AST_AUTO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_ARRAY && cmd_hit && cmd_op == OP_AUTOSEL) |=> mode == MD_AUTO); // R3

endmodule

// File: rtl/dbr_read_mux.sv
module dbr_read_mux
  import dbr_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 12
) (
  input  logic [ADDR_W-1:0]                      addr,
  input  logic                                   byte_mode,
  input  logic                                   byte_hi,
  input  logic                                   cfg_top,
  input  logic                                   ext_locked,
  input  logic [2*(1<<(ADDR_W-2-BLK_LSB))-1:0]   prot_map,
  input  logic [DATA_W-1:0]                      array_word,
  input  logic [DATA_W-1:0]                      cfi_word,
  input  logic [DATA_W/2-1:0]                    status_byte,
  input  src_e                                   src_a,
  input  src_e                                   src_b,
  output logic [DATA_W-1:0]                      data,
  output logic                                   hi_en
);

  localparam int BANK_LSB = ADDR_W - 2;
  localparam int BLK_W    = BANK_LSB - BLK_LSB;
  localparam int LANE_W   = DATA_W / 2;

  logic              bank;
  src_e              src;
  logic              prot_bit;
  logic [LANE_W-1:0] code_lo, code_hi, lane;
  logic [DATA_W-1:0] word;

  always_comb begin
    bank     = (addr[ADDR_W-1:BANK_LSB] != (cfg_top ? 2'b11 : 2'b00));
    src      = bank ? src_b : src_a;
    prot_bit = prot_map[{bank, addr[BANK_LSB-1:BLK_LSB]}];

    unique case (addr[1:0])
      2'b00: code_lo = MFR_CODE;
      2'b01: code_lo = cfg_top ? DEV_TOP : DEV_BOT;
      2'b10: code_lo = {{(LANE_W-1){1'b0}}, prot_bit};
      default: code_lo = addr[6] ? '0 : (ext_locked ? XV_LOCKED : XV_OPEN);
    endcase
    code_hi = (addr[1:0] == 2'b01) ? DEV_UPPER : '0;

    unique case (src)
      SRC_ARRAY: word = array_word;
      SRC_CODE:  word = {code_hi, code_lo};
      SRC_CFI:   word = cfi_word;
      default:   word = {{LANE_W{1'b0}}, status_byte};
    endcase

    if (src == SRC_ARRAY && byte_hi) lane = word[DATA_W-1:LANE_W];
    else                             lane = word[LANE_W-1:0];

    data  = byte_mode ? {{LANE_W{1'b0}}, lane} : word;
    hi_en = !byte_mode;
  end

endmodule

// File: rtl/dual_bank_read_router.sv
module dual_bank_read_router
  import dbr_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 12
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [ADDR_W-1:0]                    rd_addr,
  input  logic                                 rd_byte_mode,
  input  logic                                 rd_byte_hi,
  input  logic                                 cfg_top_boot,
  input  logic                                 ext_locked,
  input  logic [2*(1<<(ADDR_W-2-BLK_LSB))-1:0] prot_map,
  input  logic [DATA_W-1:0]                    array_word,
  input  logic [DATA_W-1:0]                    cfi_word,
  input  logic [DATA_W/2-1:0]                  status_byte,
  input  logic                                 cmd_valid,
  input  logic [1:0]                           cmd_op,
  input  logic                                 cmd_bank,
  input  logic [1:0]                           pe_busy,
  input  logic [1:0]                           pe_error,
  output logic [DATA_W-1:0]                    rd_data,
  output logic                                 rd_hi_en
);

  localparam int NBANK  = 2;
  localparam int LANE_W = DATA_W / 2;

  bank_mode_e        mode_w [NBANK];
  src_e              src_w  [NBANK];
  logic [DATA_W-1:0] data_d;
  logic              hi_en_d;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    dbr_bank_mode u_mode (
      .clk        (clk),
      .rst        (rst),
      .cmd_hit    (cmd_valid && (cmd_bank == 1'(g))),
      .cmd_op     (cmd_op_e'(cmd_op)),
      .other_prog (mode_w[NBANK-1-g] == MD_PROG),
      .busy       (pe_busy[g]),
      .err        (pe_error[g]),
      .mode       (mode_w[g]),
      .src        (src_w[g])
    );
  end

  dbr_read_mux #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .BLK_LSB (BLK_LSB)
  ) u_mux (
    .addr        (rd_addr),
    .byte_mode   (rd_byte_mode),
    .byte_hi     (rd_byte_hi),
    .cfg_top     (cfg_top_boot),
    .ext_locked  (ext_locked),
    .prot_map    (prot_map),
    .array_word  (array_word),
    .cfi_word    (cfi_word),
    .status_byte (status_byte),
    .src_a       (src_w[0]),
    .src_b       (src_w[1]),
    .data        (data_d),
    .hi_en       (hi_en_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_hi_en <= 1'b0;
    end else begin
      rd_data  <= data_d;
      rd_hi_en <= hi_en_d;
    end
  end

  AST_SINGLE_PROGRAMMER: assert property (@(posedge clk) disable iff (rst)
    !(mode_w[0] == MD_PROG && mode_w[1] == MD_PROG)); // R8

  AST_BYTE_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rd_byte_mode) |-> (!rd_hi_en && rd_data[DATA_W-1:LANE_W] == '0)); // R9

endmodule

// File: tb/dual_bank_read_router_bench.sv
module dual_bank_read_router_bench;
  import dbr_pkg::*;

  localparam int AW = 21;
  localparam int DW = 16;
  localparam int BL = 12;
  localparam int PB = 2 * (1 << (AW - 2 - BL));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_byte_mode = 1'b0, rd_byte_hi = 1'b0;
  logic          cfg_top_boot = 1'b0, ext_locked = 1'b1;
  logic [PB-1:0] prot_map = '0;
  logic [DW-1:0] array_word = '0, cfi_word = '0;
  logic [7:0]    status_byte = '0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic          cmd_bank = 1'b0;
  logic [1:0]    pe_busy = 2'b00, pe_error = 2'b00;
  logic [DW-1:0] rd_data;
  logic          rd_hi_en;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bank_mode_e m [2];
  bit sn [2];
  bit rt [2];
  int bzc [2];

  always #5 clk = ~clk;

  dual_bank_read_router #(.ADDR_W(AW), .DATA_W(DW), .BLK_LSB(BL)) u_dual_bank_read_router (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_byte_mode(rd_byte_mode),
    .rd_byte_hi(rd_byte_hi), .cfg_top_boot(cfg_top_boot), .ext_locked(ext_locked),
    .prot_map(prot_map), .array_word(array_word), .cfi_word(cfi_word),
    .status_byte(status_byte), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .pe_busy(pe_busy), .pe_error(pe_error),
    .rd_data(rd_data), .rd_hi_en(rd_hi_en));

  function automatic logic [1:0] bank_a_hi();
    return cfg_top_boot ? 2'b11 : 2'b00;
  endfunction

  task automatic calc(output logic [16:0] e, output string t);
    int b;
    logic [15:0] w;
    logic [7:0] lo;
    b = (rd_addr[20:19] == bank_a_hi()) ? 0 : 1;
    case (m[b])
      MD_AUTO: begin
        case (rd_addr[1:0])
          2'b00: w = 16'h0020;
          2'b01: w = cfg_top_boot ? 16'h225E : 16'h225F;
          2'b10: w = {15'd0, prot_map[{b[0], rd_addr[18:12]}]};
          default: w = rd_addr[6] ? 16'h0000 : (ext_locked ? 16'h0081 : 16'h0001);
        endcase
        t = rd_addr[1] ? "R4" : "R3";
      end
      MD_CFI: begin w = cfi_word; t = "R5"; end
      MD_ERR: begin w = {8'h00, status_byte}; t = "R7"; end
      MD_PROG: begin
        if (sn[b] && !pe_busy[b] && !pe_error[b]) w = array_word;
        else w = {8'h00, status_byte};
        t = "R6";
      end
      default: begin w = array_word; t = "R2"; end
    endcase
    if (rd_byte_mode) begin
      lo = (m[b] == MD_ARRAY || (m[b] == MD_PROG && w == array_word && sn[b] && !pe_busy[b] && !pe_error[b]))
           && rd_byte_hi ? w[15:8] : w[7:0];
      e = {1'b0, 8'h00, lo};
      t = "R9";
    end else begin
      e = {1'b1, w};
    end
  endtask

  task automatic advance();
    bank_mode_e nm [2];
    bit nsn [2];
    bit nrt [2];
    for (int b = 0; b < 2; b++) begin
      bit hit;
      hit = cmd_valid && (cmd_bank == b[0]);
      nm[b] = m[b]; nsn[b] = sn[b]; nrt[b] = rt[b];
      case (m[b])
        MD_ARRAY: if (hit) begin
          if (cmd_op == 2'd1) nm[b] = MD_AUTO;
          else if (cmd_op == 2'd2) begin nm[b] = MD_CFI; nrt[b] = 0; end
          else if (cmd_op == 2'd3 && m[1-b] != MD_PROG) begin nm[b] = MD_PROG; nsn[b] = 0; end
        end
        MD_AUTO: if (hit) begin
          if (cmd_op == 2'd0) nm[b] = MD_ARRAY;
          else if (cmd_op == 2'd2) begin nm[b] = MD_CFI; nrt[b] = 1; end
        end
        MD_CFI: if (hit && cmd_op == 2'd0) nm[b] = rt[b] ? MD_AUTO : MD_ARRAY;
        MD_PROG: begin
          if (pe_busy[b]) nsn[b] = 1;
          else if (sn[b]) nm[b] = pe_error[b] ? MD_ERR : MD_ARRAY;
        end
        default: if (hit && cmd_op == 2'd0) nm[b] = MD_ARRAY;
      endcase
    end
    for (int b = 0; b < 2; b++) begin m[b] = nm[b]; sn[b] = nsn[b]; rt[b] = nrt[b]; end
  endtask

  task automatic step(input string tag);
    logic [16:0] e;
    string t;
    calc(e, t);
    if (tag != "") t = tag;
    @(posedge clk);
    advance();
    #1;
    n_cmp++;
    if ({rd_hi_en, rd_data} !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, {rd_hi_en, rd_data}, e);
    end
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic bk, input string tag);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bk;
    step(tag);
    cmd_valid = 1'b0;
  endtask

  task automatic drive_busy();
    for (int b = 0; b < 2; b++) begin
      if (m[b] == MD_PROG) begin
        if (bzc[b] > 0) begin
          bzc[b]--;
          pe_busy[b] = (bzc[b] != 0);
        end else if (!sn[b] && !pe_busy[b] && ($urandom % 2 == 0)) begin
          bzc[b] = int'($urandom % 5) + 2;
          pe_busy[b] = 1'b1;
        end
      end else begin
        pe_busy[b] = 1'b0;
        bzc[b] = 0;
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1: watchdog expired, actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < PB / 32; i++) prot_map[i*32 +: 32] = $urandom;
    m[0] = MD_ARRAY; m[1] = MD_ARRAY;
    sn[0] = 0; sn[1] = 0; rt[0] = 0; rt[1] = 0; bzc[0] = 0; bzc[1] = 0;
    array_word = 16'hA5C3; cfi_word = 16'h5152; status_byte = 8'h80;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if ({rd_hi_en, rd_data} !== 17'd0) begin
      n_bad++;
      $display("FAIL R1: actual %h expected %h", {rd_hi_en, rd_data}, 17'd0);
    end
    rst = 1'b0;

    // R3 / R4: identification reads on bank A, bank B unaffected (R2)
    rd_addr = '0;
    issue(2'd1, 1'b0, "R3");
    step("R3");
    rd_addr = 21'h000001; step("R3");
    rd_byte_mode = 1'b1; step("R9");
    rd_byte_mode = 1'b0;
    rd_addr = {2'b01, 19'h00001}; step("R2");
    rd_addr = {2'b00, 7'd5, 10'd0, 2'b10}; step("R4");
    rd_addr = {2'b00, 7'd6, 10'd0, 2'b10}; step("R4");
    rd_addr = 21'h000003; step("R4");
    ext_locked = 1'b0; step("R4");
    rd_addr = 21'h000043; step("R4");

    // R5: query mode entry and return path
    issue(2'd2, 1'b0, "R5");
    step("R5");
    issue(2'd0, 1'b0, "R5");
    rd_addr = 21'h000000; step("R5");
    issue(2'd0, 1'b0, "R5");
    step("R5");

    // R6 / R8: program bank B, commands ignored while busy
    rd_addr = {2'b01, 19'h00100};
    issue(2'd3, 1'b1, "R6");
    step("R6");
    pe_busy[1] = 1'b1;
    step("R6"); step("R6");
    issue(2'd1, 1'b1, "R8");
    rd_addr = 21'h000010;
    issue(2'd3, 1'b0, "R8");
    step("R8");
    rd_addr = {2'b01, 19'h00100};
    pe_busy[1] = 1'b0;
    step("R6");
    step("R8");

    // R7: program bank A ending in error
    rd_addr = 21'h000020;
    issue(2'd3, 1'b0, "R7");
    pe_busy[0] = 1'b1; step("R7");
    pe_busy[0] = 1'b0; pe_error[0] = 1'b1; step("R7");
    pe_error[0] = 1'b0; step("R7");
    issue(2'd1, 1'b0, "R7");
    step("R7");
    issue(2'd0, 1'b0, "R7");
    step("R7");

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      rd_addr = AW'($urandom);
      if ($urandom % 2 == 0) rd_addr[20:19] = bank_a_hi();
      if ($urandom % 3 == 0) rd_addr[6] = 1'b0;
      rd_byte_mode = ($urandom % 3 == 0);
      rd_byte_hi = 1'($urandom);
      array_word = 16'($urandom);
      cfi_word = 16'($urandom);
      status_byte = 8'($urandom);
      pe_error = {($urandom % 4 == 0), ($urandom % 4 == 0)};
      cmd_valid = ($urandom % 6 == 0);
      cmd_op = 2'($urandom);
      cmd_bank = 1'($urandom);
      if (i % 1000 == 999) cfg_top_boot = ~cfg_top_boot;
      if (i % 97 == 0) ext_locked = 1'($urandom);
      drive_busy();
      step("");
    end
    cmd_valid = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule